// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a core and its coherent data cache and holds stores that have retired but have not yet been written into the cache. A store whose line is not yet writable (the cache does not hold it with write permission) is accepted at once, so the core keeps running while the ownership request is outstanding. Each entry carries a word address, write data and byte enables, plus a sticky flag that records whether its line may now be written. The cache announces that ownership of a line has arrived by pulsing a grant with the line number. Entries whose flag is set are written out through a cache write port.

Loads from the core probe the buffer by word address. The youngest buffered store to that address is returned, so the core sees its own stores in program order even before they reach the cache. A barrier input holds back new stores until the buffer has drained. The full form of the barrier also waits for the invalidate queue, which lies outside this block, to report that it is empty.

The store port and the cache write port are valid/ready. A store transfers in a cycle where `st_valid` and `st_ready` are both high. `st_ready` does not depend on `st_valid` in the same cycle. The cache write port offers an entry by raising `cw_valid`, and the entry leaves the buffer in a cycle where `cw_ready` is also high. Once an entry has been offered, it stays on the port with unchanged address, data and enables until it is taken. A store accepted in one cycle is visible to load lookups from the next cycle on.

Top module: `store_fwd_buffer`

## Requirements
- R1: `st_ready` is high whenever fewer than DEPTH entries are held and `bar_busy` is low. An accepted store becomes one more held entry in the next cycle.
- R2: While DEPTH entries are held, `st_ready` is low and the core stalls.
- R3: `ld_fwd_hit` is high exactly when a held entry has the word address on `ld_addr`. With an empty buffer it is low.
- R4: When several held entries match `ld_addr`, `ld_fwd_data` and `ld_fwd_be` come from the most recently accepted of them.
- R5: An entry may be offered on the cache write port only after its line is writable. This holds when the entry was accepted with `st_line_owned` high, or when a grant for its line arrived in or after the cycle it was accepted. With no such entry, `cw_valid` is low.
- R6: Among the entries that may be offered, the oldest one whose address matches no older held entry is offered. Stores to the same address therefore leave in program order, while a store to another address may overtake an older store that is still waiting for its line.
- R7: While `cw_valid` is high and `cw_ready` is low, the next cycle offers the same entry with unchanged `cw_addr`, `cw_data` and `cw_be`, even if a grant makes an older entry eligible meanwhile.
- R8: `bar_kind` = 1 (write barrier) drives `bar_busy` high while any entry is held. `bar_kind` = 0 keeps it low.
- R9: `bar_kind` = 2 or 3 (full barrier) drives `bar_busy` high while any entry is held or while `invq_empty` is low.
- R10: While `bar_busy` is high, `st_ready` is low.
- R11: After reset the buffer is empty: `st_ready` is high, and `cw_valid`, `ld_fwd_hit` and `bar_busy` are low while no barrier is requested.
- R12: The line number of a word address is the address shifted right by LINE_OFS bits. `gnt_valid` with `gnt_line` marks every held entry of that line, and a store accepted in the same cycle, as writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Buffer accepts the store |
| st_addr | input | AW | Word address of the store |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_line_owned | input | 1 | The line is already writable when the store is offered |
| ld_addr | input | AW | Word address of the load lookup |
| ld_fwd_hit | output | 1 | A buffered store matches the load |
| ld_fwd_data | output | DW | Data of the youngest matching store |
| ld_fwd_be | output | DW/8 | Byte enables of the youngest matching store |
| cw_valid | output | 1 | An entry is offered to the cache |
| cw_ready | input | 1 | Cache takes the offered entry |
| cw_addr | output | AW | Word address of the offered entry |
| cw_data | output | DW | Data of the offered entry |
| cw_be | output | DW/8 | Byte enables of the offered entry |
| gnt_valid | input | 1 | Ownership of a line has been granted |
| gnt_line | input | AW-LINE_OFS | Line number of the grant |
| bar_kind | input | 2 | 0 none, 1 write barrier, 2 or 3 full barrier |
| invq_empty | input | 1 | Invalidate queue outside the block is empty |
| bar_busy | output | 1 | The requested barrier is still waiting |

## Verification
Addresses are drawn from four lines of four words each, so repeated addresses and shared lines occur all the time. A directed run stacks two stores to one address behind a store whose line is already owned. This separates youngest-match forwarding from oldest-match forwarding, and it also separates bypass of a waiting store from a strict FIFO drain. Holding the cache port stalled while a grant arrives shows whether the offered entry stays fixed. A full buffer held under each barrier kind, with the invalidate queue first busy and then empty, separates the two barrier forms. Random grant, ready and barrier patterns then check every output against a bench model of the queue in every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    BAR_NONE  = 2'd0,
    BAR_WRITE = 2'd1,
    BAR_FULL  = 2'd2,
    BAR_FULLX = 2'd3
  } bar_kind_e;

  // Barrier still waiting, given the requested kind and queue states.
  function automatic logic barrier_waits(input logic [1:0] kind,
                                         input logic      sb_empty,
                                         input logic      iq_empty);
    logic w;
    case (bar_kind_e'(kind))
      BAR_NONE:  w = 1'b0;
      BAR_WRITE: w = !sb_empty;
      default:   w = !sb_empty || !iq_empty;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH    = 8,
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int LINE_OFS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               push,
  input  logic [AW-1:0]                      push_addr,
  input  logic [DW-1:0]                      push_data,
  input  logic [DW/8-1:0]                    push_be,
  input  logic                               push_own,
  input  logic                               pop,
  input  logic [$clog2(DEPTH)-1:0]           pop_idx,
  input  logic                               gnt_valid,
  input  logic [AW-LINE_OFS-1:0]             gnt_line,
  output logic [DEPTH-1:0][AW-1:0]           q_addr,
  output logic [DEPTH-1:0][DW-1:0]           q_data,
  output logic [DEPTH-1:0][DW/8-1:0]         q_be,
  output logic [DEPTH-1:0]                   q_own,
  output logic [$clog2(DEPTH+1)-1:0]         q_cnt
);
  localparam int IW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int BEW = DW/8;

  logic [DEPTH-1:0][AW-1:0]  n_addr;
  logic [DEPTH-1:0][DW-1:0]  n_data;
  logic [DEPTH-1:0][BEW-1:0] n_be;
  logic [DEPTH-1:0]          n_own;
  logic [CW-1:0]             n_cnt;

  // Age-ordered slots: index 0 is oldest. A pop closes the gap, then
  // grants mark lines, then a push lands at the first free slot.
  always_comb begin
    n_addr = q_addr;
    n_data = q_data;
    n_be   = q_be;
    n_own  = q_own;
    n_cnt  = q_cnt;
    if (pop) begin
      for (int i = 0; i < DEPTH-1; i++) begin
        if (IW'(i) >= pop_idx) begin
          n_addr[i] = q_addr[i+1];
          n_data[i] = q_data[i+1];
          n_be[i]   = q_be[i+1];
          n_own[i]  = q_own[i+1];
        end
      end
      n_cnt = q_cnt - CW'(1);
    end
    if (gnt_valid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (n_addr[i][AW-1:LINE_OFS] == gnt_line) n_own[i] = 1'b1;
      end
    end
    if (push) begin
      n_addr[IW'(n_cnt)] = push_addr;
      n_data[IW'(n_cnt)] = push_data;
      n_be[IW'(n_cnt)]   = push_be;
      n_own[IW'(n_cnt)]  = push_own ||
                           (gnt_valid && (push_addr[AW-1:LINE_OFS] == gnt_line));
      n_cnt = n_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_addr <= '0;
      q_data <= '0;
      q_be   <= '0;
      q_own  <= '0;
      q_cnt  <= '0;
    end else begin
      q_addr <= n_addr;
      q_data <= n_data;
      q_be   <= n_be;
      q_own  <= n_own;
      q_cnt  <= n_cnt;
    end
  end

endmodule

// File: rtl/sb_drain_pick.sv
module sb_drain_pick #(
  parameter int DEPTH = 8,
  parameter int AW    = 12
) (
  input  logic [DEPTH-1:0][AW-1:0]     q_addr,
  input  logic [DEPTH-1:0]             q_own,
  input  logic [$clog2(DEPTH+1)-1:0]   q_cnt,
  input  logic                         hold,
  input  logic [$clog2(DEPTH)-1:0]     hold_idx,
  output logic                         found,
  output logic [$clog2(DEPTH)-1:0]     idx
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DEPTH-1:0] elig;

  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    logic older_same;
    always_comb begin
      older_same = 1'b0;
      for (int j = 0; j < g; j++) begin
        if (q_addr[j] == q_addr[g]) older_same = 1'b1;
      end
    end
    assign elig[g] = (CW'(g) < q_cnt) && q_own[g] && !older_same;
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
    if (hold) begin
      found = 1'b1;
      idx   = hold_idx;
    end
  end

endmodule

// File: rtl/sb_fwd_lookup.sv
module sb_fwd_lookup #(
  parameter int DEPTH = 8,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic [DEPTH-1:0][AW-1:0]     q_addr,
  input  logic [DEPTH-1:0][DW-1:0]     q_data,
  input  logic [DEPTH-1:0][DW/8-1:0]   q_be,
  input  logic [$clog2(DEPTH+1)-1:0]   q_cnt,
  input  logic [AW-1:0]                ld_addr,
  output logic                         hit,
  output logic [DW-1:0]                data,
  output logic [DW/8-1:0]              be
);
  localparam int CW = $clog2(DEPTH+1);

  // Later (younger) slots override earlier ones.
  always_comb begin
    hit  = 1'b0;
    data = '0;
    be   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < q_cnt) && (q_addr[i] == ld_addr)) begin
        hit  = 1'b1;
        data = q_data[i];
        be   = q_be[i];
      end
    end
  end

endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int LINE_OFS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   st_valid,
  output logic                   st_ready,
  input  logic [AW-1:0]          st_addr,
  input  logic [DW-1:0]          st_data,
  input  logic [DW/8-1:0]        st_be,
  input  logic                   st_line_owned,
  input  logic [AW-1:0]          ld_addr,
  output logic                   ld_fwd_hit,
  output logic [DW-1:0]          ld_fwd_data,
  output logic [DW/8-1:0]        ld_fwd_be,
  output logic                   cw_valid,
  input  logic                   cw_ready,
  output logic [AW-1:0]          cw_addr,
  output logic [DW-1:0]          cw_data,
  output logic [DW/8-1:0]        cw_be,
  input  logic                   gnt_valid,
  input  logic [AW-LINE_OFS-1:0] gnt_line,
  input  logic [1:0]             bar_kind,
  input  logic                   invq_empty,
  output logic                   bar_busy
);
  localparam int IW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH+1);
  localparam int BEW = DW/8;

  logic [DEPTH-1:0][AW-1:0]  q_addr;
  logic [DEPTH-1:0][DW-1:0]  q_data;
  logic [DEPTH-1:0][BEW-1:0] q_be;
  logic [DEPTH-1:0]          q_own;
  logic [CW-1:0]             occ;
  logic                      push, pop;
  logic                      hold;
  logic [IW-1:0]             hold_idx;
  logic                      pick_found;
  logic [IW-1:0]             pick_idx;

  assign bar_busy = barrier_waits(bar_kind, occ == '0, invq_empty);
  assign st_ready = (occ != CW'(DEPTH)) && !bar_busy;
  assign push     = st_valid && st_ready;
  assign pop      = cw_valid && cw_ready;

  sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LINE_OFS(LINE_OFS)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (st_addr),
    .push_data (st_data),
    .push_be   (st_be),
    .push_own  (st_line_owned),
    .pop       (pop),
    .pop_idx   (pick_idx),
    .gnt_valid (gnt_valid),
    .gnt_line  (gnt_line),
    .q_addr    (q_addr),
    .q_data    (q_data),
    .q_be      (q_be),
    .q_own     (q_own),
    .q_cnt     (occ)
  );

  sb_drain_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick (
    .q_addr   (q_addr),
    .q_own    (q_own),
    .q_cnt    (occ),
    .hold     (hold),
    .hold_idx (hold_idx),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  sb_fwd_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .q_addr  (q_addr),
    .q_data  (q_data),
    .q_be    (q_be),
    .q_cnt   (occ),
    .ld_addr (ld_addr),
    .hit     (ld_fwd_hit),
    .data    (ld_fwd_data),
    .be      (ld_fwd_be)
  );

  // Pin the offered entry while the cache back-pressures.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold     <= 1'b0;
      hold_idx <= '0;
    end else begin
      hold     <= cw_valid && !cw_ready;
      hold_idx <= pick_idx;
    end
  end

  assign cw_valid = pick_found;
  assign cw_addr  = q_addr[pick_idx];
  assign cw_data  = q_data[pick_idx];
  assign cw_be    = q_be[pick_idx];

endmodule

// File: rtl/store_fwd_buffer_chk.sv
module store_fwd_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       st_ready,
  input logic                       cw_valid,
  input logic                       cw_ready,
  input logic [AW-1:0]              cw_addr,
  input logic [DW-1:0]              cw_data,
  input logic [DW/8-1:0]            cw_be,
  input logic                       ld_fwd_hit,
  input logic                       bar_busy,
  input logic                       push,
  input logic                       pop,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int CW = $clog2(DEPTH+1);

  p_occ_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> occ == $past(occ) + CW'($past(push)) - CW'($past(pop)));

  p_full_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> !st_ready);

  p_empty_no_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !ld_fwd_hit);

  p_empty_no_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !cw_valid);

  p_cw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cw_ready) |=> cw_valid && $stable(cw_addr)
                                && $stable(cw_data) && $stable(cw_be));

  p_barrier_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bar_busy |-> !st_ready);

endmodule

bind store_fwd_buffer store_fwd_buffer_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_ready   (st_ready),
  .cw_valid   (cw_valid),
  .cw_ready   (cw_ready),
  .cw_addr    (cw_addr),
  .cw_data    (cw_data),
  .cw_be      (cw_be),
  .ld_fwd_hit (ld_fwd_hit),
  .bar_busy   (bar_busy),
  .push       (push),
  .pop        (pop),
  .occ        (occ)
);

// File: tb/store_fwd_buffer_tb_top.sv
module store_fwd_buffer_tb_top;
  localparam int DEPTH    = 8;
  localparam int AW       = 12;
  localparam int DW       = 32;
  localparam int LINE_OFS = 2;
  localparam int BEW      = DW/8;
  localparam int LW       = AW-LINE_OFS;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           st_valid = 1'b0, st_ready, st_line_owned = 1'b0;
  logic [AW-1:0]  st_addr = '0;
  logic [DW-1:0]  st_data = '0;
  logic [BEW-1:0] st_be = '0;
  logic [AW-1:0]  ld_addr = '0;
  logic           ld_fwd_hit;
  logic [DW-1:0]  ld_fwd_data;
  logic [BEW-1:0] ld_fwd_be;
  logic           cw_valid, cw_ready = 1'b0;
  logic [AW-1:0]  cw_addr;
  logic [DW-1:0]  cw_data;
  logic [BEW-1:0] cw_be;
  logic           gnt_valid = 1'b0;
  logic [LW-1:0]  gnt_line = '0;
  logic [1:0]     bar_kind = 2'd0;
  logic           invq_empty = 1'b1;
  logic           bar_busy;

  always #5 clk = ~clk;

  store_fwd_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LINE_OFS(LINE_OFS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .st_be(st_be), .st_line_owned(st_line_owned),
    .ld_addr(ld_addr), .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data), .ld_fwd_be(ld_fwd_be),
    .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_addr(cw_addr), .cw_data(cw_data), .cw_be(cw_be),
    .gnt_valid(gnt_valid), .gnt_line(gnt_line),
    .bar_kind(bar_kind), .invq_empty(invq_empty), .bar_busy(bar_busy)
  );

  int vectors = 0;
  int fails   = 0;

  // Bench model of the buffer, index 0 oldest.
  int             m_cnt = 0;
  logic [AW-1:0]  m_addr [DEPTH];
  logic [DW-1:0]  m_data [DEPTH];
  logic [BEW-1:0] m_be   [DEPTH];
  bit             m_own  [DEPTH];
  bit             m_hold = 0;
  int             m_hidx = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_pick();
    if (m_hold) return m_hidx;
    for (int i = 0; i < m_cnt; i++) begin
      if (m_own[i]) begin
        bit blk = 0;
        for (int j = 0; j < i; j++) if (m_addr[j] == m_addr[i]) blk = 1;
        if (!blk) return i;
      end
    end
    return -1;
  endfunction

  function automatic int model_fwd(input logic [AW-1:0] a);
    int r = -1;
    for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) r = i;
    return r;
  endfunction

  function automatic bit model_busy();
    if (bar_kind == 2'd1) return m_cnt != 0;
    if (bar_kind[1])      return (m_cnt != 0) || !invq_empty;
    return 0;
  endfunction

  // Called at a falling edge with inputs set; checks, then advances model.
  task automatic step();
    int  pk, fw;
    bit  busy, rdy, do_push, do_pop;
    #2;
    pk   = model_pick();
    fw   = model_fwd(ld_addr);
    busy = model_busy();
    rdy  = (m_cnt < DEPTH) && !busy;
    chk((bar_kind == 2'd1 || bar_kind == 2'd0) ? "R8" : "R9", bar_busy, busy);
    chk(m_cnt == DEPTH ? "R2" : (busy ? "R10" : "R1"), st_ready, rdy);
    chk(m_hold ? "R7" : "R5 R12", cw_valid, pk >= 0);
    if (pk >= 0) begin
      chk(m_hold ? "R7" : "R6", cw_addr, m_addr[pk]);
      chk(m_hold ? "R7" : "R6", cw_data, m_data[pk]);
      chk(m_hold ? "R7" : "R6", cw_be,   m_be[pk]);
    end
    chk("R3", ld_fwd_hit, fw >= 0);
    if (fw >= 0) begin
      chk("R4", ld_fwd_data, m_data[fw]);
      chk("R4", ld_fwd_be,   m_be[fw]);
    end
    do_push = st_valid && rdy;
    do_pop  = (pk >= 0) && cw_ready;
    if (do_pop) begin
      for (int i = pk; i < m_cnt-1; i++) begin
        m_addr[i] = m_addr[i+1]; m_data[i] = m_data[i+1];
        m_be[i]   = m_be[i+1];   m_own[i]  = m_own[i+1];
      end
      m_cnt--;
    end
    if (gnt_valid)
      for (int i = 0; i < m_cnt; i++) if ((m_addr[i] >> LINE_OFS) == AW'(gnt_line)) m_own[i] = 1;
    if (do_push) begin
      m_addr[m_cnt] = st_addr; m_data[m_cnt] = st_data; m_be[m_cnt] = st_be;
      m_own[m_cnt]  = st_line_owned || (gnt_valid && ((st_addr >> LINE_OFS) == AW'(gnt_line)));
      m_cnt++;
    end
    m_hold = (pk >= 0) && !cw_ready;
    m_hidx = pk;
    @(negedge clk);
  endtask

  task automatic idle();
    st_valid = 0; st_line_owned = 0; gnt_valid = 0; cw_ready = 0;
    bar_kind = 2'd0; invq_empty = 1;
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [BEW-1:0] b, input bit own);
    st_valid = 1; st_addr = a; st_data = d; st_be = b; st_line_owned = own;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    // R11: empty after reset
    chk("R11", {st_ready, cw_valid, ld_fwd_hit, bar_busy}, 4'b1000);
    @(negedge clk);

    // Two stores to word 5 wait for line 1; an owned store to word 9 bypasses.
    idle(); ld_addr = 12'd5;
    put(12'd5, 32'hAAAA_0001, 4'hF, 0); step();
    put(12'd5, 32'hBBBB_0002, 4'h3, 0); step();
    put(12'd9, 32'hCCCC_0003, 4'h8, 1); step();
    idle(); ld_addr = 12'd5; step();          // youngest match on word 5 (R4)
    step();                                   // word 9 offered, held (R6, R7)
    gnt_valid = 1; gnt_line = 10'd1; step();  // grant line 1 while held (R7, R12)
    gnt_valid = 0; cw_ready = 1;
    repeat (4) step();                        // drain 9, then 5 twice in order

    // Fill to full with waiting stores, then write barrier, then full barrier.
    idle();
    for (int k = 0; k < DEPTH; k++) begin
      put(12'h40 + AW'(k), 32'h1000 + DW'(k), 4'hF, 0); step();
    end
    put(12'h60, 32'h5555, 4'h1, 1); step(); step();  // R2: full stalls
    idle(); bar_kind = 2'd1; step(); step();         // R8 busy while held
    cw_ready = 1; gnt_valid = 1;
    for (int k = 0; k < 4; k++) begin
      gnt_line = LW'((12'h40 >> LINE_OFS) + k); step();
    end
    gnt_valid = 0;
    repeat (DEPTH + 2) step();
    bar_kind = 2'd2; invq_empty = 0; put(12'h7, 32'h77, 4'hF, 1); step(); step(); // R9
    invq_empty = 1; step(); step();
    bar_kind = 2'd3; step();

    // Random traffic.
    idle();
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 20);
      st_valid      = ($urandom % 2) == 0;
      st_addr       = AW'($urandom % 16);
      st_data       = $urandom;
      st_be         = BEW'($urandom);
      st_line_owned = ($urandom % 4) == 0;
      ld_addr       = AW'($urandom % 16);
      gnt_valid     = ($urandom % 5) == 0;
      gnt_line      = LW'($urandom % 4);
      cw_ready      = ($urandom % 5) < 3;
      bar_kind      = (r == 0) ? 2'd1 : (r == 1) ? 2'd2 : (r == 2) ? 2'd3 : 2'd0;
      invq_empty    = ($urandom % 4) != 0;
      step();
    end

    idle(); step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule